// File: doc/BRIEF.md
# Split-Half One-Shot/Periodic Down-Timer

This timer keeps its 32-bit count and its 32-bit reload value as two 16-bit halves, called A (low) and B (high). When the configuration register holds zero, the halves act as a single 32-bit down-counter. The A mode field chooses whether the counter stops after one time-out or keeps running. Software controls the block through a small word-addressed register interface with a combinational read path. One 32-bit access to the A load address or the A count address covers both halves.

When the joined counter is at zero and running, the next clock reloads the full interval and sets a sticky raw time-out flag. If trigger output is enabled, the same clock also raises a one-cycle trigger pulse. In one-shot mode that clock also clears the enable bit in hardware. The interrupt output is the raw flag gated by a mask bit. Writing 1 to bit 0 of the clear register removes the raw flag.

The register addresses (word offsets) are: 0 configuration, 1 A mode, 2 B mode, 3 control (bit 0 enable, bit 1 trigger enable), 4 joined load, 5 B load half, 6 joined count, 7 B count half, 8 mask, 9 raw status, 10 masked status, 11 clear, 12 A prescale, 13 B prescale. Status, mask and clear use bit 0.

Top module: `dht_timer`

## Requirements
- R1: After reset, addresses 4 and 6 read 0xFFFFFFFF, addresses 5 and 7 read 0x0000FFFF, and the prescale, configuration, control, mask and raw status registers read 0. `irq_o` and `trig_o` are 0.
- R2: A write to address 4 puts bits [31:16] into the B load half and bits [15:0] into the A load half. A write to address 5 changes only the B load half. Address 4 reads {B load, A load}.
- R3: Address 6 reads {B count, A count}. When the A half passes below zero it wraps to 0xFFFF and the B half is decremented, so 0x00010001 becomes 0x0000FFFF after two counting clocks.
- R4: The counter runs only when enable is 1 and configuration is 0. In that state it drops by one per clock. On the clock after it reads zero, it reloads the interval, so one period is load+1 clocks.
- R5: A mode value other than 2 selects one-shot. In one-shot mode the reload clock clears control bit 0, and the count then holds the reloaded value.
- R6: A mode value 2 selects periodic. In periodic mode the enable bit stays set and time-outs repeat every load+1 clocks.
- R7: The B mode register (address 2) can be written and read back, but it has no effect on the joined counter.
- R8: A time-out sets raw status. The flag stays set through writes of 0 to the clear register and is removed by a write with bit 0 set.
- R9: Masked status (address 10) and `irq_o` equal the raw flag ANDed with the mask bit.
- R10: `trig_o` is high for exactly the one clock after a time-out, and only when control bit 1 is set.
- R11: A clear write in the same clock as a time-out leaves raw status set.
- R12: A load write while the counter is running leaves the current count unchanged, and the new value is used at the next reload. A load write while the counter is not running also copies the value into the count.
- R13: With a nonzero configuration value, the count holds even when enable is set, and no time-out occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 2*HALF_W | Write data |
| bus_rdata | output | 2*HALF_W | Read data for bus_addr, combinational |
| irq_o | output | 1 | Time-out interrupt (masked status) |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
A wrong borrow between the halves shows up on the first clock where the A half wraps: the joined count read at address 6 then has the wrong upper half. A lost or extra reload, or a one-shot enable that is not cleared, changes the value read back in the clock right after zero, and the bench samples both the count and control bit 0 there. Status and trigger faults show on `irq_o` and `trig_o` one clock after the time-out edge. The bench checks the count at zero, on the reload clock and on the clock after it.

// File: rtl/dht_pkg.sv
package dht_pkg;
   localparam int REG_CFG     = 0;
   localparam int REG_MODE_A  = 1;
   localparam int REG_MODE_B  = 2;
   localparam int REG_CTRL    = 3;
   localparam int REG_LOAD    = 4;
   localparam int REG_LOAD_B  = 5;
   localparam int REG_COUNT   = 6;
   localparam int REG_COUNT_B = 7;
   localparam int REG_MASK    = 8;
   localparam int REG_RAW     = 9;
   localparam int REG_MASKED  = 10;
   localparam int REG_CLEAR   = 11;
   localparam int REG_PRE_A   = 12;
   localparam int REG_PRE_B   = 13;

   localparam logic [1:0] MODE_PERIODIC = 2'b10;

   typedef struct packed {
      logic trig_en;
      logic run_en;
   } ctrl_t;
endpackage

// File: rtl/dht_half.sv
module dht_half #(
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_i,
   input  logic              reload_i,
   input  logic              ld_we_i,
   input  logic [HALF_W-1:0] ld_wd_i,
   input  logic              follow_i,
   output logic [HALF_W-1:0] cnt_o,
   output logic [HALF_W-1:0] ld_o,
   output logic              zero_o
);
   localparam logic [HALF_W-1:0] RST_VAL = '1;

   logic [HALF_W-1:0] cnt_q;
   logic [HALF_W-1:0] ld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_q <= RST_VAL;
      end else if (ld_we_i) begin
         ld_q <= ld_wd_i;
      end
   end

   // reload takes the value held before this edge; a same-edge write waits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_VAL;
      end else if (reload_i) begin
         cnt_q <= ld_q;
      end else if (dec_i) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (ld_we_i && follow_i) begin
         cnt_q <= ld_wd_i;
      end
   end

   assign cnt_o  = cnt_q;
   assign ld_o   = ld_q;
   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dht_regs.sv
module dht_regs
   import dht_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int ADDR_W = 4,
   parameter int PRE_W  = 8,
   parameter int CFG_W  = 3,
   localparam int DW    = 2 * HALF_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DW-1:0]          bus_wdata,
   output logic [DW-1:0]          bus_rdata,
   input  logic [DW-1:0]          cnt_word_i,
   input  logic [DW-1:0]          ld_word_i,
   input  logic                   raw_i,
   input  logic                   masked_i,
   input  logic                   hw_stop_i,
   output logic [CFG_W-1:0]       cfg_o,
   output logic                   oneshot_o,
   output ctrl_t                  ctrl_o,
   output logic                   ctrl_wr_o,
   output logic                   mask_o,
   output logic [1:0]             ld_we_o,
   output logic [1:0][HALF_W-1:0] ld_wd_o,
   output logic                   clr_o
);
   logic              wr_hit;
   logic [CFG_W-1:0]  cfg_q;
   logic [1:0]        mode_a_q;
   logic [1:0]        mode_b_q;
   ctrl_t             ctrl_q;
   logic              mask_q;
   logic [PRE_W-1:0]  pre_a_q;
   logic [PRE_W-1:0]  pre_b_q;

   function automatic logic at(input logic [ADDR_W-1:0] a, input int r);
      return a == ADDR_W'(r);
   endfunction

   assign wr_hit    = bus_sel && bus_wr;
   assign ctrl_wr_o = wr_hit && at(bus_addr, REG_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         mode_a_q <= '0;
         mode_b_q <= '0;
         mask_q   <= 1'b0;
         pre_a_q  <= '0;
         pre_b_q  <= '0;
      end else if (wr_hit) begin
         if (at(bus_addr, REG_CFG))    cfg_q    <= bus_wdata[CFG_W-1:0];
         if (at(bus_addr, REG_MODE_A)) mode_a_q <= bus_wdata[1:0];
         if (at(bus_addr, REG_MODE_B)) mode_b_q <= bus_wdata[1:0];
         if (at(bus_addr, REG_MASK))   mask_q   <= bus_wdata[0];
         if (at(bus_addr, REG_PRE_A))  pre_a_q  <= bus_wdata[PRE_W-1:0];
         if (at(bus_addr, REG_PRE_B))  pre_b_q  <= bus_wdata[PRE_W-1:0];
      end
   end

   // a software write to control takes precedence over the one-shot stop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr_o) begin
         ctrl_q <= ctrl_t'(bus_wdata[1:0]);
      end else if (hw_stop_i) begin
         ctrl_q.run_en <= 1'b0;
      end
   end

   assign ld_we_o[0] = wr_hit && at(bus_addr, REG_LOAD);
   assign ld_we_o[1] = wr_hit && (at(bus_addr, REG_LOAD) || at(bus_addr, REG_LOAD_B));
   assign ld_wd_o[0] = bus_wdata[HALF_W-1:0];
   assign ld_wd_o[1] = at(bus_addr, REG_LOAD) ? bus_wdata[DW-1:HALF_W]
                                              : bus_wdata[HALF_W-1:0];
   assign clr_o      = wr_hit && at(bus_addr, REG_CLEAR) && bus_wdata[0];

   assign cfg_o     = cfg_q;
   assign oneshot_o = (mode_a_q != MODE_PERIODIC);
   assign ctrl_o    = ctrl_q;
   assign mask_o    = mask_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_CFG):     bus_rdata[CFG_W-1:0]  = cfg_q;
         ADDR_W'(REG_MODE_A):  bus_rdata[1:0]        = mode_a_q;
         ADDR_W'(REG_MODE_B):  bus_rdata[1:0]        = mode_b_q;
         ADDR_W'(REG_CTRL):    bus_rdata[1:0]        = ctrl_q;
         ADDR_W'(REG_LOAD):    bus_rdata             = ld_word_i;
         ADDR_W'(REG_LOAD_B):  bus_rdata[HALF_W-1:0] = ld_word_i[DW-1:HALF_W];
         ADDR_W'(REG_COUNT):   bus_rdata             = cnt_word_i;
         ADDR_W'(REG_COUNT_B): bus_rdata[HALF_W-1:0] = cnt_word_i[DW-1:HALF_W];
         ADDR_W'(REG_MASK):    bus_rdata[0]          = mask_q;
         ADDR_W'(REG_RAW):     bus_rdata[0]          = raw_i;
         ADDR_W'(REG_MASKED):  bus_rdata[0]          = masked_i;
         ADDR_W'(REG_PRE_A):   bus_rdata[PRE_W-1:0]  = pre_a_q;
         ADDR_W'(REG_PRE_B):   bus_rdata[PRE_W-1:0]  = pre_b_q;
         default:              bus_rdata             = '0;
      endcase
   end
endmodule

// File: rtl/dht_event.sv
module dht_event #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tmo_i,
   input  logic trig_en_i,
   input  logic clr_i,
   input  logic mask_i,
   output logic raw_o,
   output logic masked_o,
   output logic irq_o,
   output logic trig_o
);
   logic raw_q;
   logic trig_q;

   // a time-out in the same clock as a clear keeps the flag set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         raw_q  <= tmo_i || (raw_q && !clr_i);
         trig_q <= tmo_i && trig_en_i;
      end
   end

   assign raw_o    = raw_q;
   assign masked_o = raw_q && mask_i;
   assign trig_o   = trig_q;

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= masked_o;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = masked_o;
      end
   endgenerate
endmodule

// File: rtl/dht_timer.sv
module dht_timer
   import dht_pkg::*;
#(
   parameter int HALF_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int PRE_W   = 8,
   parameter int CFG_W   = 3,
   parameter bit IRQ_REG = 1'b0,
   localparam int DW     = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq_o,
   output logic              trig_o
);
   generate
      if (HALF_W < 2)        begin : g_bad_half $error("HALF_W must be at least 2"); end
      if (ADDR_W < 4)        begin : g_bad_addr $error("ADDR_W must cover 14 registers"); end
      if (PRE_W > DW)        begin : g_bad_pre  $error("PRE_W must fit the data word"); end
      if (CFG_W < 1 || CFG_W > DW) begin : g_bad_cfg $error("CFG_W out of range"); end
   endgenerate

   logic [CFG_W-1:0]       cfg;
   logic                   oneshot;
   ctrl_t                  ctrl;
   logic                   ctrl_wr;
   logic                   mask;
   logic [1:0]             ld_we;
   logic [1:0][HALF_W-1:0] ld_wd;
   logic                   clr;
   logic                   raw;
   logic                   masked;
   logic [1:0][HALF_W-1:0] cnt_h;
   logic [1:0][HALF_W-1:0] ld_h;
   logic [1:0]             zero_h;
   logic [1:0]             dec_h;
   logic                   run;
   logic                   all_zero;
   logic                   tmo;
   logic                   hw_stop;
   logic                   ld_we_any;
   logic [DW-1:0]          cnt_w;
   logic [DW-1:0]          ld_w;

   assign run       = ctrl.run_en && (cfg == '0);
   assign all_zero  = &zero_h;
   assign tmo       = run && all_zero;
   assign hw_stop   = tmo && oneshot;
   assign ld_we_any = |ld_we;
   assign cnt_w     = cnt_h;
   assign ld_w      = ld_h;

   // the B half moves only when the A half borrows
   assign dec_h[0] = run && !all_zero;
   assign dec_h[1] = dec_h[0] && zero_h[0];

   dht_regs #(
      .HALF_W (HALF_W),
      .ADDR_W (ADDR_W),
      .PRE_W  (PRE_W),
      .CFG_W  (CFG_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cnt_word_i (cnt_w),
      .ld_word_i  (ld_w),
      .raw_i      (raw),
      .masked_i   (masked),
      .hw_stop_i  (hw_stop),
      .cfg_o      (cfg),
      .oneshot_o  (oneshot),
      .ctrl_o     (ctrl),
      .ctrl_wr_o  (ctrl_wr),
      .mask_o     (mask),
      .ld_we_o    (ld_we),
      .ld_wd_o    (ld_wd),
      .clr_o      (clr)
   );

   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         dht_half #(.HALF_W(HALF_W)) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .dec_i    (dec_h[h]),
            .reload_i (tmo),
            .ld_we_i  (ld_we[h]),
            .ld_wd_i  (ld_wd[h]),
            .follow_i (!run),
            .cnt_o    (cnt_h[h]),
            .ld_o     (ld_h[h]),
            .zero_o   (zero_h[h])
         );
      end
   endgenerate

   dht_event #(.IRQ_REG(IRQ_REG)) u_event (
      .clk       (clk),
      .rst_n     (rst_n),
      .tmo_i     (tmo),
      .trig_en_i (ctrl.trig_en),
      .clr_i     (clr),
      .mask_i    (mask),
      .raw_o     (raw),
      .masked_o  (masked),
      .irq_o     (irq_o),
      .trig_o    (trig_o)
   );
endmodule

// File: rtl/dht_checks.sv
module dht_checks #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          tmo,
   input logic          all_zero,
   input logic          oneshot,
   input logic          ctrl_wr,
   input logic          run_en,
   input logic          trig_en,
   input logic          raw,
   input logic          clr,
   input logic          mask,
   input logic          irq_o,
   input logic          trig_o,
   input logic          ld_we_any,
   input logic [DW-1:0] cnt_w,
   input logic [DW-1:0] ld_w
);
   p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run && !all_zero |=> cnt_w == DW'($past(cnt_w) - 1'b1));

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> cnt_w == $past(ld_w));

   p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tmo && oneshot && !ctrl_wr |=> !run_en);

   p_periodic_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tmo && !oneshot && !ctrl_wr |=> run_en);

   p_tmo_sets_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> raw);

   p_raw_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      raw && !clr |=> raw);

   p_mask_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mask && !$past(mask) |-> !irq_o);

   p_trig_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> $past(trig_en) && $past(tmo));

   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !ld_we_any |=> $stable(cnt_w));
endmodule

bind dht_timer dht_checks #(.DW(DW)) u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .tmo       (tmo),
   .all_zero  (all_zero),
   .oneshot   (oneshot),
   .ctrl_wr   (ctrl_wr),
   .run_en    (ctrl.run_en),
   .trig_en   (ctrl.trig_en),
   .raw       (raw),
   .clr       (clr),
   .mask      (mask),
   .irq_o     (irq_o),
   .trig_o    (trig_o),
   .ld_we_any (ld_we_any),
   .cnt_w     (cnt_w),
   .ld_w      (ld_w)
);

// File: tb/test_dht_timer.sv
module test_dht_timer;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_o;
   logic          trig_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   dht_timer i_dht_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .trig_o    (trig_o)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      bus_addr = AW'(a);
      #1;
      v = bus_rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_reg(input string req, input int a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset;
      expect_reg("R1 count", 6, 32'hFFFF_FFFF);
      expect_reg("R1 load", 4, 32'hFFFF_FFFF);
      expect_reg("R1 load B", 5, 32'h0000_FFFF);
      expect_reg("R1 count B", 7, 32'h0000_FFFF);
      expect_reg("R1 prescale A", 12, 0);
      expect_reg("R1 prescale B", 13, 0);
      expect_reg("R1 cfg", 0, 0);
      expect_reg("R1 ctrl", 3, 0);
      expect_reg("R1 mask", 8, 0);
      expect_reg("R1 raw", 9, 0);
      check("R1 irq", 32'(irq_o), 0);
      check("R1 trig", 32'(trig_o), 0);
   endtask

   task automatic t_load_split;
      wr(4, 32'h1234_5678);
      expect_reg("R2 joined load", 4, 32'h1234_5678);
      expect_reg("R2 B load half", 5, 32'h0000_1234);
      expect_reg("R12 stopped copy", 6, 32'h1234_5678);
      wr(5, 32'h0000_ABCD);
      expect_reg("R2 B-only write", 4, 32'hABCD_5678);
   endtask

   task automatic t_borrow;
      wr(1, 1);
      wr(4, 32'h0001_0001);
      wr(3, 1);
      expect_reg("R3 start", 6, 32'h0001_0001);
      step(1);
      expect_reg("R3 A to zero", 6, 32'h0001_0000);
      step(1);
      expect_reg("R3 borrow", 6, 32'h0000_FFFF);
      expect_reg("R3 B half", 7, 0);
      wr(3, 0);
   endtask

   task automatic t_oneshot;
      wr(4, 3);
      wr(11, 1);
      wr(3, 1);
      expect_reg("R4 start", 6, 3);
      step(1);
      expect_reg("R4 dec", 6, 2);
      step(2);
      expect_reg("R4 at zero", 6, 0);
      expect_reg("R8 raw before", 9, 0);
      step(1);
      expect_reg("R4 reload", 6, 3);
      expect_reg("R8 raw set", 9, 1);
      expect_reg("R5 enable cleared", 3, 0);
      check("R10 no trig without enable", 32'(trig_o), 0);
      step(2);
      expect_reg("R5 holds", 6, 3);
   endtask

   task automatic t_modeb;
      wr(2, 2);
      expect_reg("R7 B mode stored", 2, 2);
      wr(4, 1);
      wr(11, 1);
      wr(3, 1);
      step(2);
      expect_reg("R7 still one-shot", 3, 0);
      expect_reg("R7 count", 6, 1);
      step(2);
      expect_reg("R7 holds", 6, 1);
   endtask

   task automatic t_periodic;
      wr(1, 2);
      wr(4, 2);
      wr(11, 1);
      wr(3, 3);
      step(2);
      expect_reg("R6 at zero", 6, 0);
      check("R10 trig idle", 32'(trig_o), 0);
      step(1);
      expect_reg("R6 reload", 6, 2);
      check("R10 trig pulse", 32'(trig_o), 1);
      expect_reg("R6 still enabled", 3, 3);
      step(1);
      check("R10 pulse one clock", 32'(trig_o), 0);
      expect_reg("R6 dec", 6, 1);
      step(2);
      check("R6 second time-out", 32'(trig_o), 1);
      expect_reg("R6 second reload", 6, 2);
      wr(3, 0);
   endtask

   task automatic t_trig_gate;
      int highs = 0;
      wr(4, 1);
      wr(3, 1);
      for (int i = 0; i < 6; i++) begin
         step(1);
         if (trig_o) highs++;
      end
      check("R10 gated trigger", 32'(highs), 0);
      wr(3, 0);
   endtask

   task automatic t_sticky_mask;
      expect_reg("R8 raw held", 9, 1);
      check("R9 irq masked", 32'(irq_o), 0);
      expect_reg("R9 masked reg off", 10, 0);
      wr(8, 1);
      check("R9 irq on", 32'(irq_o), 1);
      expect_reg("R9 masked reg on", 10, 1);
      wr(11, 0);
      step(5);
      expect_reg("R8 zero write keeps", 9, 1);
      wr(11, 1);
      expect_reg("R8 cleared", 9, 0);
      check("R9 irq off", 32'(irq_o), 0);
      wr(8, 0);
   endtask

   task automatic t_clear_race;
      wr(1, 2);
      wr(4, 2);
      wr(11, 1);
      wr(3, 1);
      step(2);
      expect_reg("R11 at zero", 6, 0);
      wr(11, 1);
      expect_reg("R11 event wins", 9, 1);
      wr(11, 1);
      expect_reg("R11 later clear", 9, 0);
      wr(3, 0);
   endtask

   task automatic t_reload_late;
      wr(4, 5);
      wr(3, 1);
      step(1);
      wr(4, 2);
      expect_reg("R12 count kept", 6, 3);
      expect_reg("R12 load taken", 4, 2);
      step(3);
      expect_reg("R12 at zero", 6, 0);
      step(1);
      expect_reg("R12 new value", 6, 2);
      wr(3, 0);
   endtask

   task automatic t_cfg_hold;
      wr(4, 5);
      wr(11, 1);
      wr(0, 1);
      wr(3, 1);
      step(4);
      expect_reg("R13 held", 6, 5);
      expect_reg("R13 no event", 9, 0);
      wr(0, 0);
      step(1);
      expect_reg("R13 runs after", 6, 4);
      wr(3, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_split();
      t_borrow();
      t_oneshot();
      t_modeb();
      t_periodic();
      t_trig_gate();
      t_sticky_mask();
      t_clear_race();
      t_reload_late();
      t_cfg_hold();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule